// File: doc/BRIEF.md
# Oversampled Pot Rate Controller

This block turns a stream of 10-bit potentiometer conversion results into a steady 16-bit oscillator rate word. Each conversion result arrives with a one-cycle strobe and is summed into a wide accumulator. After every 256 strobes the block evaluates the sum. It scales the sum down and adds a fixed minimum-rate offset to form a candidate rate.

The candidate replaces the stored rate only when it is far enough from that rate. Small changes from converter noise are therefore ignored, and the output only moves when the knob is really turned. The sum is thrown away after every evaluation, whether or not the candidate was taken. A one-cycle pulse marks each change of the stored rate.

Top module: `pot_rate_ctl`

## Requirements
- R1: A synchronous active-low reset sets `rate_o` to 0x0080 and `upd_o` to 0. It also discards any partly gathered window, so that the next evaluation happens on the 256th strobe after reset and uses only those 256 samples.
- R2: An evaluation takes place on every 256th strobe of `conv_valid`, and only then. `upd_o` is 0 in every cycle that does not directly follow an evaluating strobe.
- R3: At evaluation, the candidate is the sum of the 256 samples of the window shifted right by 4 (fraction bits dropped), plus 0x0080, kept to 16 bits. The sample that arrives with the evaluating strobe is part of the sum.
- R4: The stored rate takes the candidate only when the absolute difference between the two is 0x0010 or more, whether the candidate lies above or below the stored rate. A difference of 0x000F or less leaves `rate_o` unchanged and gives no pulse.
- R5: The accumulator starts again from zero after every evaluation, including evaluations where the candidate was rejected.
- R6: `upd_o` is high for exactly one cycle, in the cycle after the evaluating strobe, when the rate changes. In that same cycle `rate_o` shows the new value.
- R7: Cycles in which `conv_valid` is low do not change the sum or the strobe count, so idle gaps of any length between strobes give the same result as strobes on every cycle.
- R8: A strobe in the cycle right after an evaluation counts as the first sample of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a new conversion result is on `conv_data` |
| conv_data | input | 10 | Unsigned conversion result |
| rate_o | output | 16 | Registered oscillator rate word |
| upd_o | output | 1 | One-cycle pulse when `rate_o` changes |

## Verification
The closing strobe of a window has two jobs in the same cycle. It adds its own sample to the sum, and it starts the evaluation that clears the accumulator. If the next window then begins on the very next cycle, the fresh sample must land in a cleared sum. The bench provokes this with windows sent strobe after strobe with no gap and chained with no idle cycle. It judges the result by the next window's rate: that rate must match a candidate worked out from that window's samples alone. A rejected window followed by a window that is only accepted when the old sum was cleared checks the same clearing when nothing was updated.

// File: rtl/rc_pkg.sv
// Shared defaults for the pot rate controller.
// Assumes: nothing; holds only constants used as parameter defaults.
package rc_pkg;
    localparam int RC_ADC_W = 10;
    localparam int RC_ACC_W = 24;
    localparam int RC_CNT_W = 8;
    localparam int RC_RATE_W = 16;
    localparam int RC_SHIFT = 4;
    localparam logic [RC_RATE_W-1:0] RC_MIN_RATE = 16'h0080;
    localparam logic [RC_RATE_W-1:0] RC_DEADBAND = 16'h0010;
endpackage

// File: rtl/rc_accum.sv
// Window accumulator: sums conversion results over 2**CNT_W strobes and
// flags the strobe that closes a window.
// Assumes: conv_valid is a one-cycle strobe; ACC_W is wide enough for a full
// window of maximum samples.
module rc_accum #(
    parameter int ADC_W = 10,
    parameter int ACC_W = 24,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_valid,
    input  logic [ADC_W-1:0] conv_data,
    output logic [ACC_W-1:0] sum_now,
    output logic             eval_now
);
    localparam int PAD_W = ACC_W - ADC_W;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] left_q;

    // Running sum including the sample that is arriving this cycle.
    always_comb begin
        sum_now  = acc_q + {{PAD_W{1'b0}}, conv_data};
        eval_now = conv_valid && (left_q == '0);
    end

    // Add each strobed sample; restart from zero when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            left_q <= '1;
        end else if (conv_valid) begin
            left_q <= left_q - 1'b1;
            acc_q  <= eval_now ? '0 : sum_now;
        end
    end
endmodule

// File: rtl/rc_deadband.sv
// Candidate former and deadband test: scales a window sum, adds the minimum
// rate, and decides whether the change from the current rate is large enough.
// Assumes: purely combinational; the caller registers the result.
module rc_deadband #(
    parameter int ACC_W = 24,
    parameter int RATE_W = 16,
    parameter int SHIFT = 4,
    parameter logic [RATE_W-1:0] MIN_RATE = 16'h0080,
    parameter logic [RATE_W-1:0] DEADBAND = 16'h0010
) (
    input  logic [ACC_W-1:0]  sum_i,
    input  logic [RATE_W-1:0] cur_rate,
    output logic [RATE_W-1:0] cand_o,
    output logic              accept_o
);
    logic [RATE_W:0] delta;
    logic [RATE_W:0] mag;

    // Form the candidate and compare its distance with the threshold.
    always_comb begin
        cand_o   = RATE_W'(sum_i >> SHIFT) + MIN_RATE;
        delta    = {1'b0, cand_o} - {1'b0, cur_rate};
        mag      = delta[RATE_W] ? (~delta + 1'b1) : delta;
        accept_o = (mag >= {1'b0, DEADBAND});
    end
endmodule

// File: rtl/pot_rate_ctl.sv
// Oversampled pot rate controller: holds the oscillator rate word and
// replaces it with a new window candidate when the deadband test passes.
// Assumes: synchronous active-low reset; one-cycle conversion strobes.
module pot_rate_ctl #(
    parameter int ADC_W = rc_pkg::RC_ADC_W,
    parameter int ACC_W = rc_pkg::RC_ACC_W,
    parameter int CNT_W = rc_pkg::RC_CNT_W,
    parameter int RATE_W = rc_pkg::RC_RATE_W,
    parameter int SHIFT = rc_pkg::RC_SHIFT,
    parameter logic [RATE_W-1:0] MIN_RATE = rc_pkg::RC_MIN_RATE,
    parameter logic [RATE_W-1:0] DEADBAND = rc_pkg::RC_DEADBAND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [ADC_W-1:0]  conv_data,
    output logic [RATE_W-1:0] rate_o,
    output logic              upd_o
);
    logic [ACC_W-1:0]  win_sum;
    logic              win_eval;
    logic [RATE_W-1:0] cand;
    logic              cand_ok;

    rc_accum #(.ADC_W(ADC_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
        .conv_data(conv_data), .sum_now(win_sum), .eval_now(win_eval)
    );

    rc_deadband #(.ACC_W(ACC_W), .RATE_W(RATE_W), .SHIFT(SHIFT),
                  .MIN_RATE(MIN_RATE), .DEADBAND(DEADBAND)) u_db (
        .sum_i(win_sum), .cur_rate(rate_o), .cand_o(cand), .accept_o(cand_ok)
    );

    // Load the accepted candidate and raise the one-cycle change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_o <= MIN_RATE;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= win_eval && cand_ok;
            if (win_eval && cand_ok) rate_o <= cand;
        end
    end
endmodule

// File: rtl/rc_check.sv
// Checker for pot_rate_ctl: keeps its own strobe count and previous rate to
// judge the port behaviour over time.
// Assumes: bound to every pot_rate_ctl instance.
module rc_check #(
    parameter int CNT_W = 8,
    parameter int RATE_W = 16,
    parameter logic [RATE_W-1:0] MIN_RATE = 16'h0080,
    parameter logic [RATE_W-1:0] DEADBAND = 16'h0010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_valid,
    input logic [RATE_W-1:0] rate_o,
    input logic              upd_o
);
    logic [CNT_W-1:0]  seen_q;
    logic              closed_q;
    logic [RATE_W-1:0] prev_q;
    logic [RATE_W:0]   step;
    logic [RATE_W:0]   step_mag;

    // Independent window count and one-cycle-old rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= '0;
            closed_q <= 1'b0;
            prev_q   <= MIN_RATE;
        end else begin
            closed_q <= conv_valid && (seen_q == '1);
            if (conv_valid) seen_q <= seen_q + 1'b1;
            prev_q <= rate_o;
        end
    end

    // Size of the last rate step.
    always_comb begin
        step     = {1'b0, rate_o} - {1'b0, prev_q};
        step_mag = step[RATE_W] ? (~step + 1'b1) : step;
    end

    AST_RESET_RATE: assert property (@(posedge clk) !rst_n |=> (rate_o == MIN_RATE) && !upd_o); // R1
    AST_PULSE_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) upd_o |-> closed_q); // R2
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n) upd_o |-> step_mag >= {1'b0, DEADBAND}); // R4
    AST_STILL_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !upd_o |-> rate_o == prev_q); // R6
    AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) upd_o |-> rate_o != prev_q); // R6
    AST_RATE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) rate_o >= MIN_RATE); // R3
endmodule

bind pot_rate_ctl rc_check #(.CNT_W(CNT_W), .RATE_W(RATE_W), .MIN_RATE(MIN_RATE),
                             .DEADBAND(DEADBAND)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .rate_o(rate_o), .upd_o(upd_o)
);

// File: tb/sim_pot_rate_ctl.sv
module sim_pot_rate_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [15:0] rate_o;
    logic        upd_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] exp_rate = 16'h0080;

    pot_rate_ctl u0 (.clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
                     .conv_data(conv_data), .rate_o(rate_o), .upd_o(upd_o));

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] sample(input int mode, input int p, input int i);
        case (mode)
            0: return 10'(p);
            1: return (i < p) ? 10'd1 : 10'd0;
            default: return 10'((i * 4) % 1024);
        endcase
    endfunction

    // One window of 256 strobes; chain=1 lets the next window start at once.
    task automatic run_window(input string req, input int mode, input int p,
                              input int gap, input bit chain);
        int sum = 0;
        bit early = 0;
        logic [15:0] cand;
        int d;
        bit take;
        for (int i = 0; i < 256; i++) begin
            conv_valid = 1'b1;
            conv_data = sample(mode, p, i);
            sum += sample(mode, p, i);
            @(posedge clk);
            @(negedge clk);
            if (i < 255) begin
                if (upd_o) early = 1;
                if (gap > 0) begin
                    conv_valid = 1'b0;
                    repeat (gap) @(negedge clk);
                end
            end
        end
        cand = 16'((sum >> 4) + 128);
        d = int'(cand) - int'(exp_rate);
        if (d < 0) d = -d;
        take = (d >= 16);
        if (take) exp_rate = cand;
        check({"R2 ", req, " no pulse inside window"}, 32'(early), 32'd0);
        check({"R6 ", req, " pulse after closing strobe"}, 32'(upd_o), 32'(take));
        check({"R3 R4 ", req, " rate"}, 32'(rate_o), 32'(exp_rate));
        if (!chain) begin
            conv_valid = 1'b0;
            @(negedge clk);
            check({"R6 ", req, " pulse width"}, 32'(upd_o), 32'd0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset rate", 32'(rate_o), 32'h0080);
        check("R1 reset pulse", 32'(upd_o), 32'd0);
        rst_n = 1'b1;
        exp_rate = 16'h0080;
        @(negedge clk);
    endtask

    task automatic t_reset_midwindow();
        for (int i = 0; i < 100; i++) begin
            conv_valid = 1'b1;
            conv_data = 10'h3FF;
            @(negedge clk);
        end
        conv_valid = 1'b0;
        t_reset();
        run_window("R1 after partial window", 0, 1, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        run_window("zero window, R4 diff 0", 0, 0, 0, 0);
        run_window("R4 diff exactly 0x10 up", 0, 1, 1, 0);
        run_window("R4 R3 diff 1 truncated", 1, 255, 0, 0);
        run_window("R5 clear after reject, R4 down 0x10", 0, 0, 0, 0);
        run_window("R7 full scale with gaps", 0, 1023, 3, 1);
        run_window("R8 chained ramp", 2, 0, 0, 1);
        run_window("R8 chained ones", 0, 1, 0, 0);
        t_reset_midwindow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule